// File: doc/BRIEF.md
# PHY Register Indirect Write Bridge

This bridge turns one register-write request into the two-step command sequence that reaches a PHY register file through a single shared access register. The request carries a 16-bit data value, a register address, a lane number, a broadcast flag and a flag that selects the control path instead of a data lane. The bridge packs these into one command word. It writes that word once with the operation bit clear, then writes the same word again with the operation bit set.

After the second write, the bridge watches the PHY's busy indication, which is the operation bit as the PHY reports it back. It finishes when that indication returns to zero and pulses `done` for one cycle. If the PHY never clears the bit within a bounded number of poll cycles, the bridge pulses `err` instead and returns to idle. Requests use a valid/ready handshake, and only one request is in flight at a time.

Top module: `phy_ind_wr_bridge`

## Requirements
- R1: After reset, `req_ready` is 1 and `acc_wr`, `done` and `err` are 0.
- R2: The command word holds the request data in bits 15:0 and the register address in bits 21:16.
- R3: With broadcast clear and control clear, the lane number sits in bits 25:22. With broadcast set, bit 27 is 1 and bits 25:22 are 0.
- R4: With the control-path flag set, bit 26 is 1 and bits 25:22 are 0. Otherwise bit 26 is 0.
- R5: Each access is exactly two consecutive `acc_wr` cycles. The first has bit 31 (operation) at 0. The second has bit 31 at 1 and bits 30:0 equal to those of the first. Bits 30:28 are always 0.
- R6: From acceptance until the cycle that `done` or `err` is high, `req_ready` is 0. Requests presented in that window cause no write.
- R7: `done` is high for exactly one cycle, in the cycle after the first poll cycle in which `phy_busy` is 0. With the PHY busy for L cycles after the second write, this is L+2 cycles after that write. `req_ready` is 1 in that cycle.
- R8: If `phy_busy` stays 1 for TIMEOUT poll cycles, `err` is high for one cycle TIMEOUT+1 cycles after the second write, `done` is not raised, and the bridge returns to ready.
- R9: The first write appears in the cycle right after the handshake cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Bridge idle and able to accept |
| req_data | input | 16 | Value to write into the PHY register |
| req_addr | input | 6 | PHY register address |
| req_lane | input | 4 | Target data lane |
| req_bcast | input | 1 | Write all lanes at once |
| req_ctrl | input | 1 | Target the control PHY path |
| acc_wr | output | 1 | Write strobe to the access register |
| acc_wdata | output | 32 | Command word written to the access register |
| phy_busy | input | 1 | Operation bit as reported back by the PHY |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle timeout pulse |

## Verification
The bench sweeps every lane against all four broadcast/control combinations and varies the stub PHY latency from 0 up to one below the timeout. This exposes a field placed at the wrong offset, a lane left in the word under broadcast or control, and a completion that arrives early or late by a cycle. Latencies of exactly TIMEOUT and beyond must give `err` at a fixed cycle. An off-by-one counter would instead report success, or give up one cycle early at TIMEOUT-1. Throughout each access the bench holds a conflicting request. A bridge that did not gate acceptance would issue a third write or drop `req_ready`'s low phase. The bench also checks that each pulse lasts one cycle.

// File: rtl/phyb_pkg.sv
package phyb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOAD,
        ST_FIRE,
        ST_POLL
    } phyb_state_e;
endpackage

// File: rtl/phyb_word_pack.sv
module phyb_word_pack #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 6,
    parameter int LANE_W = 4,
    parameter int WORD_W = 32
) (
    input  logic [DATA_W-1:0] data,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LANE_W-1:0] lane,
    input  logic              bcast,
    input  logic              ctrl,
    output logic [WORD_W-1:0] word
);
    localparam int ADDR_LSB  = DATA_W;
    localparam int LANE_LSB  = ADDR_LSB + ADDR_W;
    localparam int CTRL_BIT  = LANE_LSB + LANE_W;
    localparam int BCAST_BIT = CTRL_BIT + 1;

    always_comb begin
        word = '0;
        word[DATA_W-1:0]           = data;
        word[LANE_LSB-1:ADDR_LSB]  = addr;
        word[CTRL_BIT-1:LANE_LSB]  = (bcast || ctrl) ? '0 : lane;
        word[CTRL_BIT]             = ctrl;
        word[BCAST_BIT]            = bcast;
    end
endmodule

// File: rtl/phyb_sequencer.sv
module phyb_sequencer
    import phyb_pkg::*;
#(
    parameter int WORD_W  = 32,
    parameter int TIMEOUT = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [WORD_W-1:0] word_in,
    input  logic              phy_busy,
    output logic              acc_wr,
    output logic [WORD_W-1:0] acc_wdata,
    output logic              done,
    output logic              err
);
    localparam int OP_BIT = WORD_W - 1;
    localparam int TMO_W  = (TIMEOUT > 1) ? $clog2(TIMEOUT) : 1;
    localparam logic [TMO_W-1:0] TMO_LAST = TMO_W'(TIMEOUT - 1);

    typedef struct packed {
        phyb_state_e       state;
        logic [WORD_W-1:0] word;
        logic [TMO_W-1:0]  tmo;
        logic              done;
        logic              err;
    } seq_t;

    seq_t cur_q, nxt_d;

    always_comb begin
        nxt_d      = cur_q;
        nxt_d.done = 1'b0;
        nxt_d.err  = 1'b0;
        unique case (cur_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    nxt_d.word  = word_in;
                    nxt_d.tmo   = '0;
                    nxt_d.state = ST_LOAD;
                end
            end
            ST_LOAD: nxt_d.state = ST_FIRE;
            ST_FIRE: nxt_d.state = ST_POLL;
            ST_POLL: begin
                if (!phy_busy) begin
                    nxt_d.state = ST_IDLE;
                    nxt_d.done  = 1'b1;
                end else if (cur_q.tmo == TMO_LAST) begin
                    nxt_d.state = ST_IDLE;
                    nxt_d.err   = 1'b1;
                end else begin
                    nxt_d.tmo = cur_q.tmo + 1'b1;
                end
            end
            default: nxt_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '{state: ST_IDLE, word: '0, tmo: '0, done: 1'b0, err: 1'b0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    always_comb begin
        req_ready = (cur_q.state == ST_IDLE);
        acc_wr    = (cur_q.state == ST_LOAD) || (cur_q.state == ST_FIRE);
        acc_wdata = cur_q.word;
        acc_wdata[OP_BIT] = (cur_q.state == ST_FIRE);
        done      = cur_q.done;
        err       = cur_q.err;
    end
endmodule

// File: rtl/phy_ind_wr_bridge.sv
module phy_ind_wr_bridge #(
    parameter int DATA_W  = 16,
    parameter int ADDR_W  = 6,
    parameter int LANE_W  = 4,
    parameter int WORD_W  = 32,
    parameter int TIMEOUT = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [DATA_W-1:0] req_data,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LANE_W-1:0] req_lane,
    input  logic              req_bcast,
    input  logic              req_ctrl,
    output logic              acc_wr,
    output logic [WORD_W-1:0] acc_wdata,
    input  logic              phy_busy,
    output logic              done,
    output logic              err
);
    localparam int LANE_LSB  = DATA_W + ADDR_W;
    localparam int CTRL_BIT  = LANE_LSB + LANE_W;
    localparam int BCAST_BIT = CTRL_BIT + 1;
    localparam int OP_BIT    = WORD_W - 1;

    logic [WORD_W-1:0] packed_word;

    phyb_word_pack #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .LANE_W(LANE_W), .WORD_W(WORD_W)
    ) u_pack (
        .data (req_data),
        .addr (req_addr),
        .lane (req_lane),
        .bcast(req_bcast),
        .ctrl (req_ctrl),
        .word (packed_word)
    );

    phyb_sequencer #(
        .WORD_W(WORD_W), .TIMEOUT(TIMEOUT)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(req_valid),
        .req_ready(req_ready),
        .word_in  (packed_word),
        .phy_busy (phy_busy),
        .acc_wr   (acc_wr),
        .acc_wdata(acc_wdata),
        .done     (done),
        .err      (err)
    );
endmodule

// File: rtl/phyb_checker.sv
module phyb_checker #(
    parameter int WORD_W    = 32,
    parameter int LANE_LSB  = 22,
    parameter int LANE_W    = 4,
    parameter int CTRL_BIT  = 26,
    parameter int BCAST_BIT = 27,
    parameter int OP_BIT    = 31
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              phy_busy,
    input logic              acc_wr,
    input logic [WORD_W-1:0] acc_wdata,
    input logic              done,
    input logic              err
);
    assert_second_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_wr && !acc_wdata[OP_BIT]) |=>
            (acc_wr && acc_wdata[OP_BIT] && acc_wdata[OP_BIT-1:0] == $past(acc_wdata[OP_BIT-1:0])));

    assert_op_then_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_wr && acc_wdata[OP_BIT]) |=> !acc_wr);

    assert_no_write_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !acc_wr);

    assert_first_after_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (acc_wr && !acc_wdata[OP_BIT]));

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_after_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(!phy_busy) && req_ready));

    assert_excl_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err));

    assert_bcast_lane_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_wr && acc_wdata[BCAST_BIT]) |-> (acc_wdata[CTRL_BIT-1:LANE_LSB] == '0));

    assert_ctrl_lane_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_wr && acc_wdata[CTRL_BIT]) |-> (acc_wdata[LANE_LSB+LANE_W-1:LANE_LSB] == '0));
endmodule

bind phy_ind_wr_bridge phyb_checker #(
    .WORD_W(WORD_W), .LANE_LSB(LANE_LSB), .LANE_W(LANE_W),
    .CTRL_BIT(CTRL_BIT), .BCAST_BIT(BCAST_BIT), .OP_BIT(OP_BIT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .phy_busy(phy_busy), .acc_wr(acc_wr), .acc_wdata(acc_wdata),
    .done(done), .err(err)
);

// File: tb/tb_phy_ind_wr_bridge.sv
module tb_phy_ind_wr_bridge;
    localparam int T = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [15:0] req_data = '0;
    logic [5:0]  req_addr = '0;
    logic [3:0]  req_lane = '0;
    logic        req_bcast = 1'b0;
    logic        req_ctrl = 1'b0;
    logic        acc_wr;
    logic [31:0] acc_wdata;
    logic        phy_busy;
    logic        done;
    logic        err;

    int total = 0;
    int bad = 0;
    int lat = 0;
    int stub_cnt = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    phy_ind_wr_bridge #(.TIMEOUT(T)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_data(req_data), .req_addr(req_addr), .req_lane(req_lane),
        .req_bcast(req_bcast), .req_ctrl(req_ctrl), .acc_wr(acc_wr),
        .acc_wdata(acc_wdata), .phy_busy(phy_busy), .done(done), .err(err)
    );

    // Stub PHY: busy for lat cycles after the operation write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phy_busy <= 1'b0;
            stub_cnt <= 0;
        end else if (acc_wr && acc_wdata[31]) begin
            phy_busy <= (lat != 0);
            stub_cnt <= lat;
        end else if (phy_busy) begin
            if (stub_cnt == 1) phy_busy <= 1'b0;
            stub_cnt <= stub_cnt - 1;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_req(input logic [15:0] d, input logic [5:0] a, input logic [3:0] ln,
                           input bit bc, input bit ct, input int l, input bit exp_err);
        logic [31:0] w;
        int n;
        int extra;
        int rdy_bad;
        w = {4'b0000, 32'(bc) << 27 >> 28, 28'h0} ; // placeholder zeroed below
        w = 32'(d) | (32'(a) << 16) | ((bc || ct) ? 32'h0 : (32'(ln) << 22))
            | (32'(ct) << 26) | (32'(bc) << 27);
        lat = l;
        @(negedge clk);
        req_data = d; req_addr = a; req_lane = ln; req_bcast = bc; req_ctrl = ct;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        // R9 / R2 / R3 / R4: first write directly after handshake
        check(acc_wr && acc_wdata == w, "R9 R2 R3 R4 first write", acc_wdata, w);
        @(negedge clk);
        check(acc_wr && acc_wdata == (w | 32'h8000_0000), "R5 second write", acc_wdata, w | 32'h8000_0000);
        // conflicting request held while busy (R6)
        req_data = ~d; req_addr = ~a; req_lane = ~ln; req_valid = 1'b1;
        n = 0; extra = 0; rdy_bad = 0;
        do begin
            @(negedge clk);
            n++;
            if (acc_wr) extra++;
            if (req_ready && !(done || err)) rdy_bad++;
        end while (!(done || err) && n < 40);
        req_valid = 1'b0;
        check(extra == 0 && rdy_bad == 0, "R6 no write or ready while busy", 32'(extra + rdy_bad), 32'd0);
        if (exp_err) begin
            check(err && !done && n == T + 1, "R8 timeout err timing", 32'(n), 32'(T + 1));
        end else begin
            check(done && !err && n == l + 2, "R7 done timing", 32'(n), 32'(l + 2));
        end
        check(req_ready == 1'b1, "R7 R8 ready at end", 32'(req_ready), 32'd1);
        @(negedge clk);
        check(!done && !err, "R7 R8 single-cycle pulse", {30'd0, done, err}, 32'd0);
        if (exp_err) repeat (20) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready && !acc_wr && !done && !err, "R1 reset state",
              {28'd0, req_ready, acc_wr, done, err}, 32'h8);
        for (int ln = 0; ln < 16; ln++) begin
            for (int m = 0; m < 4; m++) begin
                run_req(16'hA5C3 ^ 16'(ln * 16'h1111) ^ 16'(m),
                        6'((ln * 5 + m * 3) % 64), 4'(ln), m[0], m[1], (ln + m) % T, 1'b0);
            end
        end
        // boundaries: full fields, zero latency, latency at T-1, timeout cases
        run_req(16'hFFFF, 6'h3F, 4'hF, 1'b0, 1'b0, 0, 1'b0);
        run_req(16'h0000, 6'h00, 4'h0, 1'b1, 1'b1, T - 1, 1'b0);
        run_req(16'h1234, 6'h15, 4'h9, 1'b0, 1'b0, T, 1'b1);
        run_req(16'h4321, 6'h2A, 4'h6, 1'b1, 1'b0, T + 3, 1'b1);
        run_req(16'hBEEF, 6'h01, 4'h3, 1'b0, 1'b1, 3, 1'b0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=finish", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule